// File: doc/BRIEF.md
# Segmented DAC Code Decoder

This block converts each signed audio sample into the control codes for a three-part converter back end. The sample is first moved from two's complement to offset binary, then split into three fields. The coarse field picks a tap on a resistor ladder, and the outputs treat that tap and the one above it as the two candidate levels. The middle field sets a time-domain duty: within a repeating frame of clock slots, the upper tap is selected for a number of slots equal to the field. The fine field becomes a pair of trim codes, one at each end of the ladder, whose sum is always the same.

A sample arrives with a one-cycle valid strobe and may come at any time. It is held until the current frame ends, and all outputs then change together in the first slot of the next frame. A converter therefore never sees a mix of old and new fields. If several samples arrive within one frame, the newest one is used. While reset is high, the outputs show the code for digital zero, which is analog mid-scale.

Top module: `seg_dac_decoder`

## Requirements
- R1: While `rst` is high, and until a later sample is loaded, `tap_idx` is 2^(TAP_W-1) (256 by default), `tap_hi_sel` is 0, `trim_bot` is 0 and `trim_top` is 2^TRIM_W-1 (63).
- R2: `tap_idx` equals sample bits [17:9] with bit 17 inverted, so the most negative sample gives tap 0, zero gives 256 and the most positive gives 511.
- R3: For the sample bits [8:6] read as an unsigned count N (0 to 7), `tap_hi_sel` is 1 in slots 0 to N-1 of each 8-slot frame and 0 in the remaining slots. When N is 0 it is never 1.
- R4: `trim_bot` equals sample bits [5:0], and `trim_top` equals 63 minus that value.
- R5: `trim_top + trim_bot` equals 63 in every cycle.
- R6: A frame lasts 8 clock cycles, and the first frame begins in the first cycle after `rst` falls. `tap_idx`, the trim codes and the duty count change only in the first slot of a frame.
- R7: When several strobes fall within one frame, the next frame uses the last of them.
- R8: A strobe while `rst` is high is ignored.
- R9: A strobe in the last slot of a frame takes effect in the first slot of the very next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one PWM slot per cycle |
| rst | input | 1 | Synchronous active-high reset and initialization |
| sample_vld | input | 1 | One-cycle strobe marking a new sample |
| sample_in | input | SAMPLE_W | Two's-complement audio sample |
| tap_idx | output | TAP_W | Lower tap of the selected ladder interval |
| tap_hi_sel | output | 1 | 1 selects the upper tap in this slot, 0 the lower |
| trim_top | output | TRIM_W | Trim code for the top of the ladder |
| trim_bot | output | TRIM_W | Trim code for the bottom of the ladder |

## Verification
The bench builds the block with its default widths: an 18-bit sample, a 9-bit tap field and a 3-bit duty field, which leaves a 6-bit trim. With the 8-slot frame, every duty count from 0 to 7 fits into a few cycles, so the bench can reach the ladder ends (taps 0 and 511), both trim extremes, strobes in the last slot of a frame and several strobes inside one frame many times over in a short run. It also places a strobe inside the reset window.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

  // Source chosen for the active code at a frame boundary
  typedef enum logic [1:0] {
    SRC_KEEP = 2'd0,
    SRC_PEND = 2'd1,
    SRC_LIVE = 2'd2
  } load_src_e;

endpackage

// File: rtl/sdd_code_split.sv
module sdd_code_split #(
  parameter int SAMPLE_W = 18,
  parameter int TAP_W    = 9,
  parameter int PWM_W    = 3
) (
  input  logic [SAMPLE_W-1:0] sample,
  output logic [SAMPLE_W-1:0] code_ob
);

  // Sign flip turns two's complement into offset binary; fields stay packed
  // as {tap, pwm, trim} from the top bit down.
  always_comb begin
    code_ob               = sample;
    code_ob[SAMPLE_W-1]   = ~sample[SAMPLE_W-1];
  end

endmodule

// File: rtl/sdd_frame_timer.sv
module sdd_frame_timer #(
  parameter int PWM_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  output logic [PWM_W-1:0] slot_q,
  output logic [PWM_W-1:0] slot_nxt,
  output logic             frame_last
);

  localparam logic [PWM_W-1:0] LAST_SLOT = '1;

  // Held at the last slot during reset so slot 0 follows release.
  always_comb begin
    if (rst) slot_nxt = LAST_SLOT;
    else     slot_nxt = slot_q + 1'b1;
  end

  assign frame_last = (slot_q == LAST_SLOT);

  always_ff @(posedge clk) begin
    slot_q <= slot_nxt;
  end

endmodule

// File: rtl/sdd_code_hold.sv
module sdd_code_hold
  import sdd_pkg::*;
#(
  parameter int SAMPLE_W = 18,
  parameter int TAP_W    = 9,
  parameter int PWM_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_last,
  input  logic                sample_vld,
  input  logic [SAMPLE_W-1:0] live_code,
  output logic [SAMPLE_W-1:0] act_code,
  output logic [SAMPLE_W-1:0] act_code_nxt,
  output logic [SAMPLE_W-TAP_W-PWM_W-1:0] trim_top
);

  localparam int TRIM_W = SAMPLE_W - TAP_W - PWM_W;
  localparam logic [TRIM_W-1:0]   TRIM_MAX = '1;
  localparam logic [SAMPLE_W-1:0] MID_CODE = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W-1:0] pend_code;
  logic                pend_vld;
  load_src_e           src;

  always_comb begin
    src = SRC_KEEP;
    if (frame_last) begin
      if (sample_vld)    src = SRC_LIVE;
      else if (pend_vld) src = SRC_PEND;
    end
  end

  always_comb begin
    if (rst) begin
      act_code_nxt = MID_CODE;
    end else begin
      unique case (src)
        SRC_LIVE: act_code_nxt = live_code;
        SRC_PEND: act_code_nxt = pend_code;
        default:  act_code_nxt = act_code;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    act_code <= act_code_nxt;
    trim_top <= TRIM_MAX - act_code_nxt[TRIM_W-1:0];
  end

  // Pending slot: newest strobe overwrites, cleared at each boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld  <= 1'b0;
      pend_code <= MID_CODE;
    end else if (frame_last) begin
      pend_vld  <= 1'b0;
    end else if (sample_vld) begin
      pend_vld  <= 1'b1;
      pend_code <= live_code;
    end
  end

endmodule

// File: rtl/sdd_pwm_gen.sv
module sdd_pwm_gen #(
  parameter int PWM_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PWM_W-1:0] slot_nxt,
  input  logic [PWM_W-1:0] duty_nxt,
  output logic             hi_sel
);

  // Registered compare on next-state values keeps it aligned with the slot.
  always_ff @(posedge clk) begin
    if (rst) hi_sel <= 1'b0;
    else     hi_sel <= (slot_nxt < duty_nxt);
  end

endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder #(
  parameter int SAMPLE_W = 18,
  parameter int TAP_W    = 9,
  parameter int PWM_W    = 3
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                sample_vld,
  input  logic [SAMPLE_W-1:0]                 sample_in,
  output logic [TAP_W-1:0]                    tap_idx,
  output logic                                tap_hi_sel,
  output logic [SAMPLE_W-TAP_W-PWM_W-1:0]     trim_top,
  output logic [SAMPLE_W-TAP_W-PWM_W-1:0]     trim_bot
);

  localparam int TRIM_W   = SAMPLE_W - TAP_W - PWM_W;
  localparam int PWM_LSB  = TRIM_W;
  localparam int TAP_LSB  = TRIM_W + PWM_W;

  logic [SAMPLE_W-1:0] live_code;
  logic [SAMPLE_W-1:0] act_code;
  logic [SAMPLE_W-1:0] act_code_nxt;
  logic [PWM_W-1:0]    slot_w;
  logic [PWM_W-1:0]    slot_nxt;
  logic                frame_last;
  logic [PWM_W-1:0]    act_pwm_w;

  sdd_code_split #(
    .SAMPLE_W (SAMPLE_W),
    .TAP_W    (TAP_W),
    .PWM_W    (PWM_W)
  ) u_split (
    .sample  (sample_in),
    .code_ob (live_code)
  );

  sdd_frame_timer #(
    .PWM_W (PWM_W)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .slot_q     (slot_w),
    .slot_nxt   (slot_nxt),
    .frame_last (frame_last)
  );

  sdd_code_hold #(
    .SAMPLE_W (SAMPLE_W),
    .TAP_W    (TAP_W),
    .PWM_W    (PWM_W)
  ) u_hold (
    .clk          (clk),
    .rst          (rst),
    .frame_last   (frame_last),
    .sample_vld   (sample_vld),
    .live_code    (live_code),
    .act_code     (act_code),
    .act_code_nxt (act_code_nxt),
    .trim_top     (trim_top)
  );

  sdd_pwm_gen #(
    .PWM_W (PWM_W)
  ) u_pwm (
    .clk      (clk),
    .rst      (rst),
    .slot_nxt (slot_nxt),
    .duty_nxt (act_code_nxt[TAP_LSB-1:PWM_LSB]),
    .hi_sel   (tap_hi_sel)
  );

  assign tap_idx   = act_code[SAMPLE_W-1:TAP_LSB];
  assign act_pwm_w = act_code[TAP_LSB-1:PWM_LSB];
  assign trim_bot  = act_code[TRIM_W-1:0];

endmodule

// File: rtl/sdd_checker.sv
module sdd_checker #(
  parameter int TAP_W  = 9,
  parameter int PWM_W  = 3,
  parameter int TRIM_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [PWM_W-1:0]  slot,
  input logic [PWM_W-1:0]  act_pwm,
  input logic [TAP_W-1:0]  tap_idx,
  input logic              tap_hi_sel,
  input logic [TRIM_W-1:0] trim_top,
  input logic [TRIM_W-1:0] trim_bot
);

  localparam logic [TAP_W-1:0]  MID_TAP  = {1'b1, {(TAP_W-1){1'b0}}};
  localparam logic [TRIM_W:0]   TRIM_SUM = {1'b0, {TRIM_W{1'b1}}};
  localparam logic [PWM_W-1:0]  LAST     = '1;

  AST_RESET_MIDSCALE: assert property (@(posedge clk)
    rst |=> (tap_idx == MID_TAP && !tap_hi_sel && trim_bot == '0)); // R1

  AST_TRIM_SUM: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, trim_top} + {1'b0, trim_bot}) == TRIM_SUM); // R5

  AST_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (rst)
    (slot != '0) |-> ($stable(tap_idx) && $stable(trim_bot) && $stable(act_pwm))); // R6

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    (slot == LAST) |=> (slot == '0)); // R6

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst)
    (act_pwm == '0) |-> !tap_hi_sel); // R3

  AST_HI_PREFIX: assert property (@(posedge clk) disable iff (rst)
    (slot != '0 && tap_hi_sel) |-> $past(tap_hi_sel)); // R3

endmodule

bind seg_dac_decoder sdd_checker #(
  .TAP_W  (TAP_W),
  .PWM_W  (PWM_W),
  .TRIM_W (SAMPLE_W - TAP_W - PWM_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .slot       (slot_w),
  .act_pwm    (act_pwm_w),
  .tap_idx    (tap_idx),
  .tap_hi_sel (tap_hi_sel),
  .trim_top   (trim_top),
  .trim_bot   (trim_bot)
);

// File: tb/seg_dac_decoder_tb.sv
module seg_dac_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_vld = 1'b0;
  logic [17:0] sample_in = '0;
  logic [8:0]  tap_idx;
  logic        tap_hi_sel;
  logic [5:0]  trim_top;
  logic [5:0]  trim_bot;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_dac_decoder u_dut (
    .clk        (clk),
    .rst        (rst),
    .sample_vld (sample_vld),
    .sample_in  (sample_in),
    .tap_idx    (tap_idx),
    .tap_hi_sel (tap_hi_sel),
    .trim_top   (trim_top),
    .trim_bot   (trim_bot)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_slot = 7;
  int m_code = 32'h20000;
  int m_hi   = 0;
  int pend_q[$];
  bit started = 0;

  function automatic int to_ob(input logic [17:0] s);
    return int'(s) ^ 32'h20000;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_slot = 7;
      m_code = 32'h20000;
      pend_q.delete();
      m_hi = 0;
    end else begin
      if (m_slot == 7) begin
        if (sample_vld) m_code = to_ob(sample_in);
        else if (pend_q.size() > 0) m_code = pend_q[$];
        pend_q.delete();
      end else if (sample_vld) begin
        pend_q.push_back(to_ob(sample_in));
      end
      m_slot = (m_slot + 1) % 8;
      m_hi = (m_slot < ((m_code >> 6) & 7)) ? 1 : 0;
    end
  end

  int prev_tap = 256;
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2", int'(tap_idx), m_code >> 9);
      chk("R3", int'(tap_hi_sel), m_hi);
      chk("R4", int'(trim_bot), m_code & 63);
      chk("R4", int'(trim_top), 63 - (m_code & 63));
      chk("R5", int'(trim_top) + int'(trim_bot), 63);
      if (!rst && m_slot != 0) chk("R6", int'(tap_idx), prev_tap);
      prev_tap = int'(tap_idx);
    end
  end

  task automatic strobe(input logic [17:0] s);
    @(negedge clk);
    sample_vld = 1'b1;
    sample_in  = s;
    @(negedge clk);
    sample_vld = 1'b0;
  endtask

  task automatic wait_slot(input int s);
    do @(negedge clk); while (m_slot != s);
  endtask

  task automatic count_frame(output int n);
    wait_slot(0);
    n = int'(tap_hi_sel);
    repeat (7) begin
      @(negedge clk);
      n += int'(tap_hi_sel);
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    logic [31:0] seed;
    seed = 32'h1234_5678;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", int'(tap_idx), 256);
    chk("R1", int'(tap_hi_sel), 0);
    chk("R1", int'(trim_bot), 0);
    chk("R1", int'(trim_top), 63);
    rst = 1'b0;
    @(negedge clk);
    chk("R6", m_slot, 0);
    chk("R1", int'(tap_idx), 256);

    // R2/R3/R4: most positive
    strobe(18'h1FFFF);
    count_frame(n);
    chk("R3", n, 7);
    chk("R2", int'(tap_idx), 511);
    chk("R4", int'(trim_top), 0);
    chk("R4", int'(trim_bot), 63);

    // Most negative: tap 0, duty 0
    strobe(18'h20000);
    count_frame(n);
    chk("R3", n, 0);
    chk("R2", int'(tap_idx), 0);

    // Minus one
    strobe(18'h3FFFF);
    count_frame(n);
    chk("R2", int'(tap_idx), 255);
    chk("R3", n, 7);

    // Every duty count
    for (int d = 0; d < 8; d++) begin
      strobe(18'(d << 6) | 18'h00015);
      count_frame(n);
      chk("R3", n, d);
      chk("R4", int'(trim_bot), 21);
    end

    // R7: newest strobe in a frame wins
    wait_slot(0);
    sample_vld = 1'b1; sample_in = 18'h00040;
    @(negedge clk);
    sample_vld = 1'b0;
    @(negedge clk);
    sample_vld = 1'b1; sample_in = 18'h00180;
    @(negedge clk);
    sample_vld = 1'b0;
    count_frame(n);
    chk("R7", n, 6);
    chk("R7", int'(tap_idx), 256);

    // R9: strobe in last slot takes effect next frame
    wait_slot(7);
    sample_vld = 1'b1; sample_in = 18'h10000;
    @(negedge clk);
    sample_vld = 1'b0;
    chk("R9", int'(tap_idx), 384);

    // R8: strobe during reset ignored
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    sample_vld = 1'b1; sample_in = 18'h1FFFF;
    @(negedge clk);
    sample_vld = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    count_frame(n);
    chk("R8", int'(tap_idx), 256);
    chk("R8", n, 0);

    // Sweep with irregular gaps, checked every cycle
    for (int i = 0; i < 300; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      strobe(seed[29:12]);
      repeat (int'(seed[3:0]) % 13) @(negedge clk);
    end
    repeat (20) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule